// File: doc/BRIEF.md
# Key-Protected Clock Configuration Register Bank

This block holds the configuration that a clock generator needs: enables for the fast and slow oscillators, the system clock source select, the PLL settings (power, multiplier code, W code, loop-filter resistance, VCO constant) and two clock divider codes. Software reaches the registers through a simple synchronous bus. A write lands on the clock edge where select and write are both high. Read data is a combinational function of the address.

A guard register protects the three configuration registers. Writing the 16-bit word 0x0096 to the guard opens the bank. Writing any other word closes it again. While the bank is closed, writes to the configuration registers are dropped and reads still work. The oscillators, the PLL and the clock multiplexer are outside this block. It drives their settings as plain outputs, together with the decoded PLL multiplication factor and W value.

Register word addresses: 0 = source register, 1 = PLL register, 2 = divider register, 3 = guard register.

Top module: `clkcfg_top`

## Requirements
- R1: After reset the outputs are as follows. Both oscillator enables are 1, the source select is 0b00 (fast oscillator), PLL power is 0, and both divider codes are 0 (ratio 1/1). The PLL register reads 0x1804: W code 0b01, resistance 0b1000, VCO 0b0001, multiplier code 0. The bank is closed after reset.
- R2: A write of exactly 0x0096 to address 3 opens the bank from the next cycle. Address 3 then reads 0x0001.
- R3: A write of any other value to address 3 closes the bank. Address 3 then reads 0x0000. Address 3 accepts writes whether the bank is open or closed.
- R4: While the bank is closed, writes to addresses 0, 1 and 2 change neither the stored value nor any output.
- R5: Reads of every address return the stored contents whether the bank is open or closed. Unused bits read 0.
- R6: The PLL register (address 1) has this layout: bit 0 power, bits [3:2] W code, bits [7:4] multiplier code, bits [11:8] filter resistance, bits [15:12] VCO constant. Bit 1 is unused.
- R7: The output pllFactor equals the multiplier code plus one, giving x1 to x16.
- R8: W codes 0b01, 0b10 and 0b11 give a pllWValue of 2, 4 and 8. A write with W code 0b00 keeps the stored W code and still updates the other PLL fields.
- R9: The source register (address 0) has this layout: bit 0 fast oscillator enable, bit 1 slow oscillator enable, bits [3:2] source select. srcIsPll is 1 exactly when the select is 0b11.
- R10: The divider register (address 2) has this layout: bits [3:0] main clock divider code, bits [7:4] module clock divider code.
- R11: An accepted write appears on the outputs and the read data in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus select |
| busWr | input | 1 | Write enable, qualified by busSel |
| busAddr | input | 2 | Register word address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr |
| hsOscEn | output | 1 | Fast oscillator enable |
| lsOscEn | output | 1 | Slow oscillator enable |
| srcSel | output | 2 | System clock source select |
| srcIsPll | output | 1 | Source select picks the PLL |
| pllPwr | output | 1 | PLL power |
| pllMultCode | output | 4 | PLL multiplier code |
| pllFactor | output | 5 | Multiplication factor, 1 to 16 |
| pllWCode | output | 2 | Stored W code |
| pllWValue | output | 4 | W value 2, 4 or 8 |
| pllResCode | output | 4 | Loop-filter resistance code |
| pllVcoCode | output | 4 | VCO constant code |
| mainDivCode | output | 4 | Main clock divider code |
| modDivCode | output | 4 | Module clock divider code |

## Verification
A corrupted lock bit has two visible effects on the next write. It either lets a closed-bank write change an output one cycle later, or it drops an open-bank write, and address 3 reads back the wrong value at once. A wrong field store shows up one cycle after the write, both in the read data and in the decoded factor and W outputs. Each write is therefore followed by checks of the readback and the outputs before the next write. A W code stored as zero would show as a W value of 1 right after the write.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int REG_DATA_W = 16;
  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    ADDR_SRC = 2'd0,
    ADDR_PLL = 2'd1,
    ADDR_DIV = 2'd2,
    ADDR_KEY = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic wrSrc;
    logic wrPll;
    logic wrDiv;
    logic unlocked;
  } ctrlStrobe_t;
endpackage

// File: rtl/clkcfg_ctrl.sv
module clkcfg_ctrl
  import clkcfg_pkg::*;
#(
  parameter int DATA_W = REG_DATA_W,
  parameter int ADDR_W = REG_ADDR_W,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 16'h0096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output ctrlStrobe_t       stb
);
  logic unlockQ;
  logic wrEn;
  logic keyHit;

  assign wrEn   = busSel && busWr;
  assign keyHit = (busWdata == UNLOCK_KEY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlockQ <= 1'b0;
    end else if (wrEn && busAddr == ADDR_KEY) begin
      unlockQ <= keyHit;
    end
  end

  always_comb begin
    stb          = '0;
    stb.unlocked = unlockQ;
    if (wrEn && unlockQ) begin
      stb.wrSrc = (busAddr == ADDR_SRC);
      stb.wrPll = (busAddr == ADDR_PLL);
      stb.wrDiv = (busAddr == ADDR_DIV);
    end
  end

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == ADDR_KEY && busWdata == UNLOCK_KEY) |=> stb.unlocked) // R2
    else $error("key write did not open bank");

  AST_OTHER_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == ADDR_KEY && busWdata != UNLOCK_KEY) |=> !stb.unlocked) // R3
    else $error("non-key write did not close bank");
endmodule

// File: rtl/clkcfg_datapath.sv
module clkcfg_datapath
  import clkcfg_pkg::*;
#(
  parameter int DATA_W = REG_DATA_W,
  parameter int ADDR_W = REG_ADDR_W,
  parameter int FIELD_W = 4,
  parameter logic [1:0]         W_RST   = 2'b01,
  parameter logic [FIELD_W-1:0] RES_RST = 4'b1000,
  parameter logic [FIELD_W-1:0] VCO_RST = 4'b0001
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               hsOscEn,
  output logic               lsOscEn,
  output logic [1:0]         srcSel,
  output logic               srcIsPll,
  output logic               pllPwr,
  output logic [FIELD_W-1:0] pllMultCode,
  output logic [FIELD_W:0]   pllFactor,
  output logic [1:0]         pllWCode,
  output logic [3:0]         pllWValue,
  output logic [FIELD_W-1:0] pllResCode,
  output logic [FIELD_W-1:0] pllVcoCode,
  output logic [FIELD_W-1:0] mainDivCode,
  output logic [FIELD_W-1:0] modDivCode
);
  localparam logic [1:0] SRC_PLL = 2'b11;

  logic               hsQ, lsQ;
  logic [1:0]         selQ;
  logic               pwrQ;
  logic [1:0]         wQ;
  logic [FIELD_W-1:0] multQ, resQ, vcoQ, mainQ, modQ;
  logic [1:0]         wIn;

  assign wIn = wrData[3:2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsQ  <= 1'b1;
      lsQ  <= 1'b1;
      selQ <= 2'b00;
    end else if (stb.wrSrc) begin
      hsQ  <= wrData[0];
      lsQ  <= wrData[1];
      selQ <= wrData[3:2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrQ  <= 1'b0;
      wQ    <= W_RST;
      multQ <= '0;
      resQ  <= RES_RST;
      vcoQ  <= VCO_RST;
    end else if (stb.wrPll) begin
      pwrQ  <= wrData[0];
      multQ <= wrData[7:4];
      resQ  <= wrData[11:8];
      vcoQ  <= wrData[15:12];
      if (wIn != 2'b00) wQ <= wIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainQ <= '0;
      modQ  <= '0;
    end else if (stb.wrDiv) begin
      mainQ <= wrData[3:0];
      modQ  <= wrData[7:4];
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADDR_SRC: rdData[3:0] = {selQ, lsQ, hsQ};
      ADDR_PLL: rdData = {vcoQ, resQ, multQ, wQ, 1'b0, pwrQ};
      ADDR_DIV: rdData[7:0] = {modQ, mainQ};
      default:  rdData[0] = stb.unlocked;
    endcase
  end

  assign hsOscEn     = hsQ;
  assign lsOscEn     = lsQ;
  assign srcSel      = selQ;
  assign srcIsPll    = (selQ == SRC_PLL);
  assign pllPwr      = pwrQ;
  assign pllMultCode = multQ;
  assign pllFactor   = {1'b0, multQ} + 1'b1;
  assign pllWCode    = wQ;
  assign pllWValue   = 4'd1 << wQ;
  assign pllResCode  = resQ;
  assign pllVcoCode  = vcoQ;
  assign mainDivCode = mainQ;
  assign modDivCode  = modQ;

  AST_W_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    pllWCode != 2'b00) // R8
    else $error("W code zero stored");

  AST_ZERO_W_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrPll && wrData[3:2] == 2'b00) |=> $stable(pllWCode)) // R8
    else $error("zero W write changed W");
endmodule

// File: rtl/clkcfg_top.sv
module clkcfg_top
  import clkcfg_pkg::*;
#(
  parameter int DATA_W = REG_DATA_W,
  parameter int ADDR_W = REG_ADDR_W,
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               hsOscEn,
  output logic               lsOscEn,
  output logic [1:0]         srcSel,
  output logic               srcIsPll,
  output logic               pllPwr,
  output logic [FIELD_W-1:0] pllMultCode,
  output logic [FIELD_W:0]   pllFactor,
  output logic [1:0]         pllWCode,
  output logic [3:0]         pllWValue,
  output logic [FIELD_W-1:0] pllResCode,
  output logic [FIELD_W-1:0] pllVcoCode,
  output logic [FIELD_W-1:0] mainDivCode,
  output logic [FIELD_W-1:0] modDivCode
);
  ctrlStrobe_t stb;

  clkcfg_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .stb(stb)
  );

  clkcfg_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWdata), .rdAddr(busAddr),
    .rdData(busRdata), .hsOscEn(hsOscEn), .lsOscEn(lsOscEn), .srcSel(srcSel),
    .srcIsPll(srcIsPll), .pllPwr(pllPwr), .pllMultCode(pllMultCode),
    .pllFactor(pllFactor), .pllWCode(pllWCode), .pllWValue(pllWValue),
    .pllResCode(pllResCode), .pllVcoCode(pllVcoCode),
    .mainDivCode(mainDivCode), .modDivCode(modDivCode)
  );

  AST_CLOSED_PLL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == ADDR_PLL && !stb.unlocked)
      |=> ($stable(pllMultCode) && $stable(pllPwr) && $stable(pllVcoCode) && $stable(pllResCode))) // R4
    else $error("closed PLL write took effect");

  AST_CLOSED_DIV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == ADDR_DIV && !stb.unlocked)
      |=> ($stable(mainDivCode) && $stable(modDivCode))) // R4
    else $error("closed divider write took effect");

  AST_CLOSED_SRC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == ADDR_SRC && !stb.unlocked)
      |=> ($stable(srcSel) && $stable(hsOscEn) && $stable(lsOscEn))) // R4
    else $error("closed source write took effect");
endmodule

// File: tb/clkcfg_top_test.sv
module clkcfg_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [15:0] busWdata = 16'd0;
  logic [15:0] busRdata;
  logic        hsOscEn, lsOscEn, srcIsPll, pllPwr;
  logic [1:0]  srcSel, pllWCode;
  logic [3:0]  pllMultCode, pllWValue, pllResCode, pllVcoCode, mainDivCode, modDivCode;
  logic [4:0]  pllFactor;

  int total = 0, bad = 0;
  bit done = 0;
  int cycles = 0;

  logic [15:0] mSrc, mPll, mDiv;
  logic        mOpen;

  always #4 clk = ~clk;

  clkcfg_top uut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
    if (a == 2'd3) mOpen = (d == 16'h0096);
    else if (mOpen) begin
      if (a == 2'd0) mSrc = {12'd0, d[3:0]};
      else if (a == 2'd2) mDiv = {8'd0, d[7:0]};
      else mPll = {d[15:4], (d[3:2] != 2'b00) ? d[3:2] : mPll[3:2], 1'b0, d[0]};
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    busAddr = a; #1; d = busRdata;
  endtask

  task automatic checkAll(input string tag);
    logic [15:0] v;
    rd(2'd0, v); chk({tag, " R5 src readback"}, v, mSrc);
    rd(2'd1, v); chk({tag, " R5 pll readback"}, v, mPll);
    rd(2'd2, v); chk({tag, " R5 div readback"}, v, mDiv);
    rd(2'd3, v); chk({tag, " R2 guard readback"}, v, {15'd0, mOpen});
    chk({tag, " R9 hsOsc"}, 16'(hsOscEn), 16'(mSrc[0]));
    chk({tag, " R9 lsOsc"}, 16'(lsOscEn), 16'(mSrc[1]));
    chk({tag, " R9 srcSel"}, 16'(srcSel), 16'(mSrc[3:2]));
    chk({tag, " R9 srcIsPll"}, 16'(srcIsPll), 16'(mSrc[3:2] == 2'b11));
    chk({tag, " R6 pwr"}, 16'(pllPwr), 16'(mPll[0]));
    chk({tag, " R6 wcode"}, 16'(pllWCode), 16'(mPll[3:2]));
    chk({tag, " R6 mult"}, 16'(pllMultCode), 16'(mPll[7:4]));
    chk({tag, " R6 res"}, 16'(pllResCode), 16'(mPll[11:8]));
    chk({tag, " R6 vco"}, 16'(pllVcoCode), 16'(mPll[15:12]));
    chk({tag, " R7 factor"}, 16'(pllFactor), 16'(mPll[7:4]) + 16'd1);
    chk({tag, " R8 wvalue"}, 16'(pllWValue), 16'd2 ** 16'(mPll[3:2]));
    chk({tag, " R10 main div"}, 16'(mainDivCode), 16'(mDiv[3:0]));
    chk({tag, " R10 mod div"}, 16'(modDivCode), 16'(mDiv[7:4]));
  endtask

  initial begin
    mSrc = 16'h0003; mPll = 16'h1804; mDiv = 16'h0000; mOpen = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkAll("R1 reset");

    // R4: closed bank ignores configuration writes
    for (int a = 0; a < 3; a++) begin
      wr(2'(a), 16'hFFFF);
      checkAll("R4 closed write");
    end

    // R2 open, R11 next-cycle visibility
    wr(2'd3, 16'h0096);
    checkAll("R2 open");

    // R6 R7 R8: PLL sweep including W code 0 hold
    for (int m = 0; m < 16; m++) begin
      for (int w = 0; w < 4; w++) begin
        wr(2'd1, {4'(m ^ 5), 4'(~m), 4'(m), 2'(w), 1'b1, 1'(m + w)});
        checkAll("R8 pll sweep R11");
      end
    end

    // R9: source sweep with junk upper bits
    for (int s = 0; s < 16; s++) begin
      wr(2'd0, {12'hABC, 4'(s)});
      checkAll("R9 src sweep");
    end

    // R10: divider sweep
    for (int d = 0; d < 256; d++) begin
      wr(2'd2, {8'h5A, 8'(d)});
      checkAll("R10 div sweep");
    end

    // R3 close with near-miss key; R5 reads while closed
    wr(2'd3, 16'h0196);
    checkAll("R3 close");
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0000);
    checkAll("R4 R5 closed reads");

    // R2 R3: guard sweep, each followed by a divider write attempt
    for (int k = 0; k < 256; k++) begin
      wr(2'd3, 16'(k));
      wr(2'd2, 16'(k + 1));
      checkAll("R3 guard sweep");
    end
    wr(2'd3, 16'h0096);
    wr(2'd3, 16'h0096);
    checkAll("R2 reopen");
    wr(2'd3, 16'h0000);
    checkAll("R3 relock");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule